// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Status

This block buffers 16-bit audio samples between a processor or DMA engine and a serial audio engine. The transmit FIFO is filled by single-cycle push strobes from the processor side and drained by the serial engine through a valid/ready word handshake. The receive FIFO runs the other way. The serial engine offers words with a valid strobe, and the processor side pops them. Each popped word comes back with a data-valid flag.

Each FIFO exposes its occupancy and four level flags. A programmable threshold per direction drives a DMA request line. Level flags and error events feed a bank of thirteen pending interrupt bits. Each bit has its own enable, and all bits are cleared by a write-one-to-clear strobe. A global enable gates the combined interrupt line. Dropping a direction's enable empties that FIFO.

Top module: `audio_fifo_stat`

## Requirements
- R1: Each FIFO holds up to DEPTH (32) words. Its 6-bit count is 0 after reset, rises by one for each accepted push, falls by one for each accepted pop, and never exceeds DEPTH.
- R2: Each 4-bit flag vector holds: bit 0 empty (count == 0), bit 1 almost-empty (count <= ALMOST, default 4), bit 2 full (count == DEPTH), bit 3 almost-full (count >= DEPTH-ALMOST).
- R3: `tx_valid_o` is high exactly when the transmit direction is enabled and its FIFO is non-empty. `tx_word_o` shows the oldest pushed word. A cycle with both `tx_valid_o` and `tx_ready_i` high removes that word, so words leave in push order.
- R4: `rx_ready_o` follows `rx_en_i`. A pop strobe loads `rx_rdata_o` at the next clock edge. If a word was present, the load is {1'b1, oldest word} and the word is removed. Otherwise the load is 17'h0, so bit 16 is clear.
- R5: A push into a full FIFO is dropped, and the count stays at DEPTH. This applies to a processor push on transmit and a serial word on receive, and either case raises that direction's overflow event.
- R6: A transmit ready with an empty transmit FIFO raises the transmit starvation event. A receive pop with an empty receive FIFO raises the receive starvation event.
- R7: `tx_dma_o` is high when the transmit direction is enabled and its count <= `tx_thresh_i`. `rx_dma_o` is high when the receive direction is enabled and its count >= `rx_thresh_i`.
- R8: A cycle with a direction's enable low empties that FIFO, so the count is 0 after the edge. Pushes and pops in a disabled direction move no data and raise no interrupt source.
- R9: The pending bits are laid out as follows:
  - Bits 0..5 are the transmit sources: empty, almost-empty, full, almost-full, starvation and overflow.
  - Bits 6..11 are the same six sources for receive.
  - Bit 12 is the word-transfer event: a transmit handshake or an accepted receive word.

  A source sets its pending bit at the next edge only when its `irq_en_i` bit is high. Level sources count only while their direction is enabled.
- R10: When `irq_clr_i` is high, each pending bit whose `irq_clr_mask_i` bit is 1 is cleared at the edge. A bit that is set in the same cycle stays set.
- R11: `irq_o` is high exactly when `irq_gen_i` is high and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit direction enable; low flushes |
| rx_en_i | input | 1 | Receive direction enable; low flushes |
| tx_thresh_i | input | 6 | Transmit DMA threshold |
| rx_thresh_i | input | 6 | Receive DMA threshold |
| tx_push_i | input | 1 | Processor push strobe into transmit FIFO |
| tx_wdata_i | input | 16 | Word pushed into transmit FIFO |
| tx_count_o | output | 6 | Transmit occupancy |
| tx_flags_o | output | 4 | Transmit level flags |
| tx_dma_o | output | 1 | Transmit DMA request |
| tx_word_o | output | 16 | Oldest transmit word to serial engine |
| tx_valid_o | output | 1 | Transmit word available |
| tx_ready_i | input | 1 | Serial engine takes the transmit word |
| rx_word_i | input | 16 | Word from serial engine |
| rx_valid_i | input | 1 | Serial engine offers a word |
| rx_ready_o | output | 1 | Receive side accepts words |
| rx_pop_i | input | 1 | Processor pop strobe from receive FIFO |
| rx_rdata_o | output | 17 | Popped word, bit 16 = valid |
| rx_count_o | output | 6 | Receive occupancy |
| rx_flags_o | output | 4 | Receive level flags |
| rx_dma_o | output | 1 | Receive DMA request |
| irq_en_i | input | 13 | Per-source interrupt enables |
| irq_gen_i | input | 1 | Global interrupt enable |
| irq_clr_i | input | 1 | Clear strobe |
| irq_clr_mask_i | input | 13 | Bits to clear when strobed |
| irq_pend_o | output | 13 | Pending interrupt bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- the occupancy bound;
- the flush after a disabled cycle;
- that a full transmit FIFO with no drain keeps its count;
- that an empty receive pop never returns a valid word;
- that a pending bit cannot appear while its enable was low;
- that the interrupt line is gated globally.

Other behaviour is shown only by the bench's scenarios:
- word ordering through both FIFOs;
- the exact flag thresholds;
- the DMA comparisons against random thresholds;
- the clear-versus-set priority;
- the word-transfer event.

The bench checks these against a queue model that runs beside the design.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int NSRC      = 13;
  localparam int SRC_DIR   = 6;   // sources per direction
  localparam int S_EMPTY   = 0;
  localparam int S_AEMPTY  = 1;
  localparam int S_FULL    = 2;
  localparam int S_AFULL   = 3;
  localparam int S_STARVE  = 4;
  localparam int S_OVF     = 5;
  localparam int RX_BASE   = SRC_DIR;
  localparam int S_WORD    = 2 * SRC_DIR;
  localparam int NFLAG     = 4;
  localparam int F_EMPTY   = 0;
  localparam int F_AEMPTY  = 1;
  localparam int F_FULL    = 2;
  localparam int F_AFULL   = 3;
endpackage

// File: rtl/afs_fifo.sv
module afs_fifo #(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  parameter int ALMOST = 4,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      push_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      pop_i,
  output logic [DW-1:0]             head_o,
  output logic [CW-1:0]             count_o,
  output logic [afs_pkg::NFLAG-1:0] flags_o,
  output logic                      ovf_o,
  output logic                      starve_o
);
  import afs_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          empty, full, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count_q == '0);
  assign full     = (count_q == CW'(DEPTH));
  assign push_ok  = en_i & push_i & ~full;
  assign pop_ok   = en_i & pop_i & ~empty;
  assign ovf_o    = en_i & push_i & full;
  assign starve_o = en_i & pop_i & empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (!en_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  assign head_o   = mem[rd_ptr_q];
  assign count_o  = count_q;

  always_comb begin
    flags_o           = '0;
    flags_o[F_EMPTY]  = empty;
    flags_o[F_AEMPTY] = (count_q <= CW'(ALMOST));
    flags_o[F_FULL]   = full;
    flags_o[F_AFULL]  = (count_q >= CW'(DEPTH - ALMOST));
  end
endmodule

// File: rtl/afs_irq.sv
module afs_irq #(
  parameter int NSRC = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gen_i,
  input  logic            clr_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        pend_q[i] <= 1'b0;
      else if (src_i[i] && en_i[i])       pend_q[i] <= 1'b1;  // set beats clear
      else if (clr_i && clr_mask_i[i])    pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = gen_i & (|pend_q);
endmodule

// File: rtl/audio_fifo_stat.sv
module audio_fifo_stat #(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  parameter int ALMOST = 4,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int NSRC   = afs_pkg::NSRC,
  parameter int NFLAG  = afs_pkg::NFLAG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic [CW-1:0]    tx_thresh_i,
  input  logic [CW-1:0]    rx_thresh_i,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_wdata_i,
  output logic [CW-1:0]    tx_count_o,
  output logic [NFLAG-1:0] tx_flags_o,
  output logic             tx_dma_o,
  output logic [DW-1:0]    tx_word_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [DW-1:0]    rx_word_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic             rx_pop_i,
  output logic [DW:0]      rx_rdata_o,
  output logic [CW-1:0]    rx_count_o,
  output logic [NFLAG-1:0] rx_flags_o,
  output logic             rx_dma_o,
  input  logic [NSRC-1:0]  irq_en_i,
  input  logic             irq_gen_i,
  input  logic             irq_clr_i,
  input  logic [NSRC-1:0]  irq_clr_mask_i,
  output logic [NSRC-1:0]  irq_pend_o,
  output logic             irq_o
);
  import afs_pkg::*;

  logic          tx_ovf, tx_starve, rx_ovf, rx_starve;
  logic [DW-1:0] rx_head;
  logic          rx_pop_ok, rx_push_ok, tx_xfer;
  logic [DW:0]   rx_rdata_q;
  logic [NSRC-1:0] src;

  afs_fifo #(.DW(DW), .DEPTH(DEPTH), .ALMOST(ALMOST), .CW(CW)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en_i),
    .push_i   (tx_push_i),
    .wdata_i  (tx_wdata_i),
    .pop_i    (tx_ready_i),
    .head_o   (tx_word_o),
    .count_o  (tx_count_o),
    .flags_o  (tx_flags_o),
    .ovf_o    (tx_ovf),
    .starve_o (tx_starve)
  );

  afs_fifo #(.DW(DW), .DEPTH(DEPTH), .ALMOST(ALMOST), .CW(CW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .push_i   (rx_valid_i),
    .wdata_i  (rx_word_i),
    .pop_i    (rx_pop_i),
    .head_o   (rx_head),
    .count_o  (rx_count_o),
    .flags_o  (rx_flags_o),
    .ovf_o    (rx_ovf),
    .starve_o (rx_starve)
  );

  assign tx_valid_o = tx_en_i & ~tx_flags_o[F_EMPTY];
  assign tx_xfer    = tx_valid_o & tx_ready_i;
  assign rx_ready_o = rx_en_i;
  assign rx_push_ok = rx_en_i & rx_valid_i & ~rx_flags_o[F_FULL];
  assign rx_pop_ok  = rx_en_i & rx_pop_i & ~rx_flags_o[F_EMPTY];

  assign tx_dma_o = tx_en_i & (tx_count_o <= tx_thresh_i);
  assign rx_dma_o = rx_en_i & (rx_count_o >= rx_thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_rdata_q <= '0;
    else if (rx_pop_i) rx_rdata_q <= rx_pop_ok ? {1'b1, rx_head} : '0;
  end
  assign rx_rdata_o = rx_rdata_q;

  always_comb begin
    src = '0;
    src[S_EMPTY]            = tx_en_i & tx_flags_o[F_EMPTY];
    src[S_AEMPTY]           = tx_en_i & tx_flags_o[F_AEMPTY];
    src[S_FULL]             = tx_en_i & tx_flags_o[F_FULL];
    src[S_AFULL]            = tx_en_i & tx_flags_o[F_AFULL];
    src[S_STARVE]           = tx_starve;
    src[S_OVF]              = tx_ovf;
    src[RX_BASE + S_EMPTY]  = rx_en_i & rx_flags_o[F_EMPTY];
    src[RX_BASE + S_AEMPTY] = rx_en_i & rx_flags_o[F_AEMPTY];
    src[RX_BASE + S_FULL]   = rx_en_i & rx_flags_o[F_FULL];
    src[RX_BASE + S_AFULL]  = rx_en_i & rx_flags_o[F_AFULL];
    src[RX_BASE + S_STARVE] = rx_starve;
    src[RX_BASE + S_OVF]    = rx_ovf;
    src[S_WORD]             = tx_xfer | rx_push_ok;
  end

  afs_irq #(.NSRC(NSRC)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .en_i       (irq_en_i),
    .gen_i      (irq_gen_i),
    .clr_i      (irq_clr_i),
    .clr_mask_i (irq_clr_mask_i),
    .pend_o     (irq_pend_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/afs_chk.sv
module afs_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int NSRC  = afs_pkg::NSRC
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_en_i,
  input logic            tx_ready_i,
  input logic [CW-1:0]   tx_count_o,
  input logic            tx_valid_o,
  input logic            rx_en_i,
  input logic            rx_pop_i,
  input logic [CW-1:0]   rx_count_o,
  input logic [DW:0]     rx_rdata_o,
  input logic [NSRC-1:0] irq_en_i,
  input logic            irq_gen_i,
  input logic [NSRC-1:0] irq_pend_o,
  input logic            irq_o
);
  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_o <= CW'(DEPTH)) && (rx_count_o <= CW'(DEPTH)));

  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (tx_count_o == '0));

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && (tx_count_o == CW'(DEPTH)) && !tx_ready_i |=> (tx_count_o == CW'(DEPTH)));

  // R4
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && rx_pop_i && (rx_count_o == '0) |=> !rx_rdata_o[DW]);

  // R3
  tx_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_count_o != '0));

  // R9
  pend_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o & ~$past(irq_pend_o) & ~$past(irq_en_i)) == '0);

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_gen_i && (irq_pend_o != '0)));
endmodule

bind audio_fifo_stat afs_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .NSRC(NSRC)) u_chk (.*);

// File: tb/sim_audio_fifo_stat.sv
`timescale 1ns/1ps
module sim_audio_fifo_stat;
  localparam int DW = 16, DEPTH = 32, ALMOST = 4, CW = 6, NSRC = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en, rx_en, tx_push, tx_ready, rx_valid, rx_pop, gen, clr;
  logic [CW-1:0] tx_th, rx_th, tx_cnt, rx_cnt;
  logic [DW-1:0] tx_wd, tx_word, rx_word;
  logic [3:0] tx_fl, rx_fl;
  logic tx_dma, rx_dma, tx_valid, rx_ready, irq;
  logic [DW:0] rx_rd;
  logic [NSRC-1:0] ien, cmask, pend;

  always #5 clk = ~clk;

  audio_fifo_stat u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_thresh_i(tx_th), .rx_thresh_i(rx_th), .tx_push_i(tx_push), .tx_wdata_i(tx_wd),
    .tx_count_o(tx_cnt), .tx_flags_o(tx_fl), .tx_dma_o(tx_dma), .tx_word_o(tx_word),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .rx_word_i(rx_word), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .rx_pop_i(rx_pop), .rx_rdata_o(rx_rd), .rx_count_o(rx_cnt),
    .rx_flags_o(rx_fl), .rx_dma_o(rx_dma), .irq_en_i(ien), .irq_gen_i(gen),
    .irq_clr_i(clr), .irq_clr_mask_i(cmask), .irq_pend_o(pend), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] txq[$], rxq[$];
  logic [NSRC-1:0] m_pend = '0;
  logic [DW:0] m_rd = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] flags_of(int n);
    return {n >= DEPTH - ALMOST, n == DEPTH, n <= ALMOST, n == 0};
  endfunction

  task automatic compare_all();
    int tc = txq.size(), rc = rxq.size();
    chk("R1 tx count", 32'(tx_cnt), 32'(tc));
    chk("R1 rx count", 32'(rx_cnt), 32'(rc));
    chk("R2 tx flags", 32'(tx_fl), 32'(flags_of(tc)));
    chk("R2 rx flags", 32'(rx_fl), 32'(flags_of(rc)));
    chk("R3 tx valid", 32'(tx_valid), 32'(tx_en && tc != 0));
    if (tc != 0) chk("R3 tx word", 32'(tx_word), 32'(txq[0]));
    chk("R4 rx ready", 32'(rx_ready), 32'(rx_en));
    chk("R4 rx rdata", 32'(rx_rd), 32'(m_rd));
    chk("R7 tx dma", 32'(tx_dma), 32'(tx_en && tc <= int'(tx_th)));
    chk("R7 rx dma", 32'(rx_dma), 32'(rx_en && rc >= int'(rx_th)));
    chk("R9 pending", 32'(pend), 32'(m_pend));
    chk("R11 irq", 32'(irq), 32'(gen && m_pend != 0));
  endtask

  function automatic void model_next();
    int tc = txq.size(), rc = rxq.size();
    logic [NSRC-1:0] s = '0;
    bit tpop, tpush, rpop, rpush;
    s[0] = tx_en && tc == 0;          s[1] = tx_en && tc <= ALMOST;
    s[2] = tx_en && tc == DEPTH;      s[3] = tx_en && tc >= DEPTH - ALMOST;
    s[4] = tx_en && tx_ready && tc == 0;
    s[5] = tx_en && tx_push && tc == DEPTH;
    s[6] = rx_en && rc == 0;          s[7] = rx_en && rc <= ALMOST;
    s[8] = rx_en && rc == DEPTH;      s[9] = rx_en && rc >= DEPTH - ALMOST;
    s[10] = rx_en && rx_pop && rc == 0;
    s[11] = rx_en && rx_valid && rc == DEPTH;
    tpop  = tx_en && tx_ready && tc != 0;
    tpush = tx_en && tx_push && tc != DEPTH;
    rpop  = rx_en && rx_pop && rc != 0;
    rpush = rx_en && rx_valid && rc != DEPTH;
    s[12] = tpop || rpush;
    m_pend = (m_pend & ~(clr ? cmask : '0)) | (s & ien);
    if (rx_pop) m_rd = rpop ? {1'b1, rxq[0]} : '0;
    if (!tx_en) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_wd);
    end
    if (!rx_en) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_word);
    end
  endfunction

  // inputs are set at a negedge; compare, advance model, cross the edge
  task automatic tick();
    #1;
    compare_all();
    model_next();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    tx_push = 0; tx_ready = 0; rx_valid = 0; rx_pop = 0; clr = 0; cmask = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b_3c4d));
    tx_en = 0; rx_en = 0; tx_th = 6'd4; rx_th = 6'd32; tx_wd = '0; rx_word = '0;
    ien = '1; gen = 1; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset tx count", 32'(tx_cnt), 0);
    chk("R2 reset tx flags", 32'(tx_fl), 32'h3);
    chk("R4 reset rdata", 32'(rx_rd), 0);
    chk("R9 reset pending", 32'(pend), 0);
    chk("R11 reset irq", 32'(irq), 0);

    // fill transmit to full plus one
    tx_en = 1;
    for (int i = 0; i <= DEPTH; i++) begin
      tx_push = 1; tx_wd = 16'(16'hA000 + i);
      tick();
    end
    idle();
    chk("R5 count held at full", 32'(tx_cnt), DEPTH);
    chk("R5 tx overflow pending", 32'(pend[5]), 1);
    chk("R3 oldest word first", 32'(tx_word), 32'hA000);
    chk("R7 no tx dma when full", 32'(tx_dma), 0);

    // clear all: full level re-sets, overflow drops
    clr = 1; cmask = '1; tick(); idle(); tick();
    chk("R10 level source set wins", 32'(pend[2]), 1);
    chk("R10 overflow cleared", 32'(pend[5]), 0);

    // flush by disable, pushes ignored while disabled
    tx_en = 0; tick();
    chk("R8 flush to zero", 32'(tx_cnt), 0);
    clr = 1; cmask = '1; tx_push = 1; tick(); idle(); tx_push = 1; tick(); idle(); tick();
    chk("R8 disabled push ignored", 32'(tx_cnt), 0);
    chk("R8 no source when disabled", 32'(pend[5:0]), 0);

    // receive starvation and data-valid
    rx_en = 1; rx_pop = 1; tick(); idle(); tick();
    chk("R4 empty pop invalid", 32'(rx_rd[16]), 0);
    chk("R6 rx starvation pending", 32'(pend[10]), 1);
    rx_valid = 1; rx_word = 16'h5A5A; tick(); idle(); rx_pop = 1; tick(); idle(); tick();
    chk("R4 valid pop", 32'(rx_rd), 32'h1_5A5A);
    tx_en = 1; tx_ready = 1; tick(); idle(); tick();
    chk("R6 tx starvation pending", 32'(pend[4]), 1);
    chk("R7 tx dma when empty", 32'(tx_dma), 1);
    ien = '0; clr = 1; cmask = '1; tick(); idle(); tick();
    chk("R9 disabled sources stay clear", 32'(pend), 0);
    gen = 0; ien = 13'h1; tick(); tick();
    chk("R11 global gate", 32'(irq), 0);

    // random phases
    for (int ph = 0; ph < 16; ph++) begin
      int pin  = (ph % 2 == 0) ? 80 : 20;
      tx_th = 6'($urandom_range(0, 33));
      rx_th = 6'($urandom_range(0, 33));
      for (int c = 0; c < 200; c++) begin
        tx_en    = ($urandom % 100) >= 2;
        rx_en    = ($urandom % 100) >= 2;
        tx_push  = ($urandom % 100) < pin;
        tx_wd    = 16'($urandom);
        tx_ready = ($urandom % 100) < 100 - pin;
        rx_valid = ($urandom % 100) < pin;
        rx_word  = 16'($urandom);
        rx_pop   = ($urandom % 100) < 100 - pin;
        gen      = ($urandom % 4) != 0;
        ien      = NSRC'($urandom);
        clr      = ($urandom % 5) == 0;
        cmask    = NSRC'($urandom);
        tick();
      end
    end
    idle();
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule